// File: doc/BRIEF.md
# Predicate Register File and Guarded Write-Back Stage

This block supplies predicated execution for a four-slot long-instruction-word datapath. It holds a small bank of single-bit predicates in flip-flops. Any slot's compare result can update them, and the guard logic of every slot can read them in the same cycle. For each slot it takes the finished result, the destination register number, the write request and the store request. It then gates these against a predicate named by the slot's own guard field. The outputs are the enables that actually reach the data register bank and the memory port.

A guard is a 3-bit predicate number and a polarity bit, so an operation can be guarded on a predicate or on its complement. Predicate 0 always reads true, so an unguarded operation points at predicate 0 with polarity clear. A plain guarded operation acts as a conditional move: it writes operand A only when the guard holds. A SELECT operation always writes. It picks operand A when the guard holds and operand B otherwise, so an if-converted choice needs one slot and one write port. Only slot 0 has a branch request input, and the block gates that request into a taken signal.

Top module: `pred_guard`

## Requirements
- R1: After reset, predicates 1 to 7 read false and predicate 0 reads true.
- R2: A compare write (cmp_we[s], target cmp_idx bits [3s+2:3s], value cmp_val[s]) takes effect at the next rising clock edge. Guards in the same cycle still see the old value.
- R3: Predicate 0 reads true at all times, and writes aimed at it have no effect.
- R4: When several slots write the same predicate in one cycle, the value from the highest-numbered writing slot is stored.
- R5: A predicate written by any slot can be read by the guard of any slot.
- R6: The guard value is the predicate selected by g_idx bits [3s+2:3s], inverted when g_neg[s] is 1. For a non-SELECT operation (sel_op[s]=0), wb_en[s] is wr_req[s] AND the guard value.
- R7: st_en[s] is st_req[s] AND the guard value, for both plain and SELECT operations.
- R8: For a SELECT operation (sel_op[s]=1), wb_en[s] equals wr_req[s] whatever the guard value. wb_data (slot s at bits [32s+31:32s]) carries opa when the guard value is true and opb when it is false.
- R9: For a non-SELECT operation, wb_data carries opa.
- R10: wb_dst for slot s (bits [5s+4:5s]) carries dst when wb_en[s] is 1 and zero otherwise.
- R11: br_taken is br_req AND the guard value of slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_we | input | 4 | Per-slot predicate write request |
| cmp_idx | input | 12 | Per-slot predicate number to write, 3 bits per slot |
| cmp_val | input | 4 | Per-slot compare outcome |
| g_idx | input | 12 | Per-slot guard predicate number, 3 bits per slot |
| g_neg | input | 4 | Per-slot guard polarity (1 = complement) |
| sel_op | input | 4 | Per-slot SELECT operation flag |
| wr_req | input | 4 | Per-slot register write request |
| st_req | input | 4 | Per-slot store request |
| dst | input | 20 | Per-slot destination register, 5 bits per slot |
| opa | input | 128 | Per-slot result or first SELECT operand |
| opb | input | 128 | Per-slot second SELECT operand |
| br_req | input | 1 | Slot 0 branch request |
| wb_en | output | 4 | Gated register write enable |
| wb_dst | output | 20 | Gated destination register |
| wb_data | output | 128 | Write-back data |
| st_en | output | 4 | Gated store enable |
| br_taken | output | 1 | Slot 0 branch taken |

## Verification
The bench writes a predicate in one cycle and reads it through a guard both before and after the clock edge. A design that forwarded the new value combinationally would report it one cycle early. It makes all four slots write one predicate at once. A design that gave priority to the lowest slot would keep the wrong outcome. It also tries to clear predicate 0, and a design that stored that write would then drop every unguarded operation. SELECT is driven with both guard outcomes and both polarities. A design that gated SELECT like a conditional move would lose the write or return the wrong operand. Store enables and the branch are checked against false guards, where a leaking side effect would show up.

// File: rtl/pred_guard.sv
module pred_guard #(
  parameter int NSLOT = 4,
  parameter int NPRED = 8,
  parameter int W     = 32,
  parameter int RW    = 5,
  localparam int PW   = $clog2(NPRED)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NSLOT-1:0]   cmp_we,
  input  logic [NSLOT*PW-1:0] cmp_idx,
  input  logic [NSLOT-1:0]   cmp_val,
  input  logic [NSLOT*PW-1:0] g_idx,
  input  logic [NSLOT-1:0]   g_neg,
  input  logic [NSLOT-1:0]   sel_op,
  input  logic [NSLOT-1:0]   wr_req,
  input  logic [NSLOT-1:0]   st_req,
  input  logic [NSLOT*RW-1:0] dst,
  input  logic [NSLOT*W-1:0] opa,
  input  logic [NSLOT*W-1:0] opb,
  input  logic               br_req,
  output logic [NSLOT-1:0]   wb_en,
  output logic [NSLOT*RW-1:0] wb_dst,
  output logic [NSLOT*W-1:0] wb_data,
  output logic [NSLOT-1:0]   st_en,
  output logic               br_taken
);

  localparam logic [NPRED-1:0] PRED_RST = NPRED'(1);

  logic [NPRED-1:0] pred_q;
  logic [NPRED-1:0] pred_d;
  logic [NSLOT-1:0] gval;

  always_comb begin
    pred_d = pred_q;
    for (int s = 0; s < NSLOT; s++)
      if (cmp_we[s]) pred_d[cmp_idx[s*PW +: PW]] = cmp_val[s];
    pred_d[0] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) pred_q <= PRED_RST;
    else        pred_q <= pred_d;

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    assign gval[s]               = pred_q[g_idx[s*PW +: PW]] ^ g_neg[s];
    assign wb_en[s]              = wr_req[s] & (sel_op[s] | gval[s]);
    assign st_en[s]              = st_req[s] & gval[s];
    assign wb_data[s*W +: W]     = (sel_op[s] & ~gval[s]) ? opb[s*W +: W] : opa[s*W +: W];
    assign wb_dst[s*RW +: RW]    = wb_en[s] ? dst[s*RW +: RW] : '0;
  end

  assign br_taken = br_req & gval[0];

endmodule

// File: rtl/pred_guard_chk.sv
module pred_guard_chk #(
  parameter int NSLOT = 4,
  parameter int NPRED = 8,
  parameter int PW    = 3
) (
  input logic                clk,
  input logic                rst_n,
  input logic [NPRED-1:0]    pred_q,
  input logic [NSLOT-1:0]    cmp_we,
  input logic [NSLOT*PW-1:0] cmp_idx,
  input logic [NSLOT-1:0]    cmp_val,
  input logic [NSLOT*PW-1:0] g_idx,
  input logic [NSLOT-1:0]    g_neg,
  input logic [NSLOT-1:0]    sel_op,
  input logic [NSLOT-1:0]    wr_req,
  input logic [NSLOT-1:0]    st_req,
  input logic [NSLOT-1:0]    wb_en,
  input logic [NSLOT-1:0]    st_en,
  input logic                br_req,
  input logic                br_taken
);

  // R3
  zero_pred_true_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_we[0] && cmp_idx[PW-1:0] == '0 |=> pred_q[0]);

  // R4
  top_slot_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_we[NSLOT-1] && cmp_idx[(NSLOT-1)*PW +: PW] != '0
    |=> pred_q[$past(cmp_idx[(NSLOT-1)*PW +: PW])] == $past(cmp_val[NSLOT-1]));

  // R11
  branch_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    br_taken |-> br_req && (pred_q[g_idx[PW-1:0]] ^ g_neg[0]));

  for (genvar s = 0; s < NSLOT; s++) begin : g_chk
    // R7
    store_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      st_en[s] |-> st_req[s] && (pred_q[g_idx[s*PW +: PW]] ^ g_neg[s]));
    // R8
    select_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sel_op[s] && wr_req[s] |-> wb_en[s]);
    // R6
    plain_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !sel_op[s] && wb_en[s] |-> wr_req[s] && (pred_q[g_idx[s*PW +: PW]] ^ g_neg[s]));
  end

endmodule

bind pred_guard pred_guard_chk #(.NSLOT(NSLOT), .NPRED(NPRED), .PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .pred_q(pred_q), .cmp_we(cmp_we), .cmp_idx(cmp_idx),
  .cmp_val(cmp_val), .g_idx(g_idx), .g_neg(g_neg), .sel_op(sel_op), .wr_req(wr_req),
  .st_req(st_req), .wb_en(wb_en), .st_en(st_en), .br_req(br_req), .br_taken(br_taken)
);

// File: tb/pred_guard_tb.sv
module pred_guard_tb;
  localparam int CLK_P = 10;
  localparam int NS = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b1;
  logic [3:0]   cmp_we = '0, cmp_val = '0, g_neg = '0, sel_op = '0, wr_req = '0, st_req = '0;
  logic [11:0]  cmp_idx = '0, g_idx = '0;
  logic [19:0]  dst = '0;
  logic [127:0] opa = '0, opb = '0;
  logic         br_req = 1'b0;
  logic [3:0]   wb_en, st_en;
  logic [19:0]  wb_dst;
  logic [127:0] wb_data;
  logic         br_taken;

  int checks = 0;
  int fails  = 0;

  always #(CLK_P/2) clk = ~clk;

  pred_guard u_dut (
    .clk(clk), .rst_n(rst_n), .cmp_we(cmp_we), .cmp_idx(cmp_idx), .cmp_val(cmp_val),
    .g_idx(g_idx), .g_neg(g_neg), .sel_op(sel_op), .wr_req(wr_req), .st_req(st_req),
    .dst(dst), .opa(opa), .opb(opb), .br_req(br_req), .wb_en(wb_en), .wb_dst(wb_dst),
    .wb_data(wb_data), .st_en(st_en), .br_taken(br_taken)
  );

  // {idx[2:0], neg, sel, req, st, exp_wb, exp_st, exp_a}
  // predicate state during the table: p0,p1,p2,p5,p7 true
  localparam logic [9:0] VEC [12] = '{
    10'b001_0_0_1_1_1_1_1,
    10'b011_0_0_1_1_0_0_1,
    10'b011_1_0_1_0_1_0_1,
    10'b101_1_0_1_1_0_0_1,
    10'b100_0_1_1_0_1_0_0,
    10'b111_0_1_1_0_1_0_1,
    10'b110_1_1_0_0_0_0_1,
    10'b000_0_0_1_1_1_1_1,
    10'b000_1_0_1_1_0_0_1,
    10'b010_0_0_0_1_0_1_1,
    10'b110_0_0_1_1_0_0_1,
    10'b111_1_1_1_0_1_0_0
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    cmp_we = '0; sel_op = '0; wr_req = '0; st_req = '0; br_req = 1'b0; g_neg = '0;
  endtask

  task automatic guard(input int s, input int idx, input bit neg);
    g_idx[s*3 +: 3] = 3'(idx);
    g_neg[s] = neg;
    wr_req[s] = 1'b1;
  endtask

  task automatic wpred(input int s, input int idx, input bit v);
    cmp_we[s] = 1'b1;
    cmp_idx[s*3 +: 3] = 3'(idx);
    cmp_val[s] = v;
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
    cmp_we = '0;
  endtask

  initial begin
    #(CLK_P*200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int s = 0; s < NS; s++) begin
      opa[s*32 +: 32] = 32'hA000_0000 + 32'(s);
      opb[s*32 +: 32] = 32'hB000_0000 + 32'(s);
      dst[s*5 +: 5]   = 5'(s + 9);
    end
    #2 rst_n = 1'b0;
    #(CLK_P*2) rst_n = 1'b1;
    tick();

    // R1: reset state seen through slot 0 guard
    for (int i = 0; i < 8; i++) begin
      idle(); guard(0, i, 1'b0); #1;
      check(wb_en[0] == (i == 0), "R1", 32'(wb_en[0]), 32'(i == 0));
    end

    // R2: write p3 from slot 2, read from slot 1 before and after the edge
    idle(); wpred(2, 3, 1'b1); guard(1, 3, 1'b0); #1;
    check(wb_en[1] == 1'b0, "R2 same cycle", 32'(wb_en[1]), 0);
    tick(); #1;
    check(wb_en[1] == 1'b1, "R2 next cycle", 32'(wb_en[1]), 1);
    // R5: same predicate seen from slot 3
    idle(); guard(3, 3, 1'b0); #1;
    check(wb_en[3] == 1'b1, "R5", 32'(wb_en[3]), 1);

    // R3: attempt to clear predicate 0
    idle(); wpred(1, 0, 1'b0); wpred(3, 0, 1'b0); tick();
    idle(); guard(2, 0, 1'b0); #1;
    check(wb_en[2] == 1'b1, "R3", 32'(wb_en[2]), 1);

    // R4: all slots write p6, top slot value 0 wins
    idle(); wpred(0, 6, 1'b1); wpred(1, 6, 1'b1); wpred(2, 6, 1'b1); wpred(3, 6, 1'b0); tick();
    idle(); guard(0, 6, 1'b0); #1;
    check(wb_en[0] == 1'b0, "R4 top slot", 32'(wb_en[0]), 0);
    idle(); wpred(0, 6, 1'b0); wpred(1, 6, 1'b0); wpred(2, 6, 1'b1); tick();
    idle(); guard(0, 6, 1'b0); #1;
    check(wb_en[0] == 1'b1, "R4 highest writer", 32'(wb_en[0]), 1);

    // table state: p1 p2 p5 p7 true, p3 p4 p6 false
    idle(); wpred(0, 1, 1'b1); wpred(1, 2, 1'b1); wpred(2, 3, 1'b0); wpred(3, 4, 1'b0); tick();
    idle(); wpred(0, 5, 1'b1); wpred(1, 6, 1'b0); wpred(2, 7, 1'b1); tick();

    for (int i = 0; i < 12; i++) begin
      automatic int s = i % NS;
      automatic logic [9:0] v = VEC[i];
      automatic logic [31:0] ed = v[0] ? 32'hA000_0000 + 32'(s) : 32'hB000_0000 + 32'(s);
      automatic logic [4:0] edst = v[2] ? 5'(s + 9) : 5'd0;
      idle();
      g_idx[s*3 +: 3] = v[9:7];
      g_neg[s]  = v[6];
      sel_op[s] = v[5];
      wr_req[s] = v[4];
      st_req[s] = v[3];
      #1;
      check(wb_en[s] == v[2], v[5] ? "R8 wb_en" : "R6 wb_en", 32'(wb_en[s]), 32'(v[2]));
      check(st_en[s] == v[1], "R7 st_en", 32'(st_en[s]), 32'(v[1]));
      check(wb_data[s*32 +: 32] == ed, v[5] ? "R8 data" : "R9 data", wb_data[s*32 +: 32], ed);
      check(wb_dst[s*5 +: 5] == edst, "R10 dst", 32'(wb_dst[s*5 +: 5]), 32'(edst));
    end

    // R11: slot 0 branch gating
    idle(); br_req = 1'b1; g_idx[2:0] = 3'd7; #1;
    check(br_taken == 1'b1, "R11 true guard", 32'(br_taken), 1);
    g_idx[2:0] = 3'd4; #1;
    check(br_taken == 1'b0, "R11 false guard", 32'(br_taken), 0);
    g_neg[0] = 1'b1; #1;
    check(br_taken == 1'b1, "R11 negated", 32'(br_taken), 1);
    br_req = 1'b0; #1;
    check(br_taken == 1'b0, "R11 no request", 32'(br_taken), 0);

    // R1: reset again clears written predicates
    idle(); rst_n = 1'b0; #1;
    guard(0, 7, 1'b0); #1;
    check(wb_en[0] == 1'b0, "R1 re-reset", 32'(wb_en[0]), 0);
    rst_n = 1'b1;
    tick();

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule